// File: doc/BRIEF.md
# Flash Automatic Word-Program Engine

This block models the device side of an embedded flash array that programs one 16-bit word on its own once software has sent a short unlock-and-program command over a plain synchronous bus. Bus writes are watched for a four-write sequence. The fourth write carries the target byte address and the word to store. The engine then goes busy for a set number of clocks and writes the word into a behavioural array. During that time every read returns a status word instead of array data.

Programming can only clear bits. If the requested word would need any bit to rise from 0 to 1, the write never verifies. The engine then stays busy until a longer time limit runs out and raises a timeout flag. Only a read/reset command brings the array back into normal reads. A separate erase hook sets every word of one sector to all ones. A reset that lands during programming leaves a defined but corrupted value in the target word.

Top module: `flash_word_prog`

## Requirements
- R1: A program starts only after three unlock writes in a row, compared on the data low byte and the full byte address: 0xAA to 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555. The next write is the program cycle. A write that does not match the expected step sends the decoder back to its first step, and the later writes of that sequence store nothing.
- R2: A program cycle at an odd byte address stores nothing. It enters the error state at once, where status reads show bit 5 set, and bit 6 reads 0 and does not toggle.
- R3: One command changes exactly one 16-bit word, at word index address>>1. Neighbouring words keep their contents.
- R4: The stored word is the old word AND the requested data, so bits are only ever cleared.
- R5: If the requested data needs any 0-to-1 change, the engine stays busy for TIMEOUT_CYC clocks. It then enters the error state, where status bit 5 reads 1, and the array word becomes old AND data.
- R6: While busy, all bus writes are ignored. This includes a full new command sequence.
- R7: While busy or in error, status bit 7 reads as the inverse of bit 7 of the requested data. Once a program completes, array reads return the true word.
- R8: Status bit 6 reads 0 on the first status read after a program starts and inverts on each later status read while busy. In the error state it holds its last value.
- R9: A program that needs no 0-to-1 change keeps the engine busy for exactly PROG_CYC clocks after the cycle that takes the program write.
- R10: If reset is asserted while busy, the target word becomes the bitwise inverse of the requested data and the engine returns to array reads.
- R11: In the error state, only a write whose data low byte is 0xF0 is accepted, and it returns the engine to array reads. Every other write, including a new program sequence, is ignored.
- R12: An erase request sets all words of the selected sector to 0xFFFF. The sector is word index bits [9:8] at default size. The request is ignored unless the engine is in array-read mode.
- R13: Read data is registered and appears the cycle after the read strobe. It reads 0 after reset. Status words have every bit other than 7, 6 and 5 at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for reads, writes and commands |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data or status word |
| erase_req | input | 1 | Erase one sector to all ones |
| erase_sect | input | SECT_W | Sector selected for erase |

## Verification
The bench targets these cases:
- A program that would raise bits. A design that trusted the request would finish after the short delay and store the raised bits, instead of timing out with only the zeros applied.
- Reads issued every cycle while busy. These expose a toggle bit that starts on the wrong phase or keeps toggling after the timeout flag rises. They also expose an off-by-one in the busy length.
- A complete second command sent during busy, and another sent in the error state. A decoder that is not gated would program the second address.
- Odd-address programs, broken and aborted unlock sequences, erases sent while busy, and a reset that lands mid-program. A design that mishandles any of these shows the wrong word on a later array read.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef enum logic [1:0] {
    ST_READ = 2'd0,
    ST_BUSY = 2'd1,
    ST_FAIL = 2'd2
  } fwp_state_e;

  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  KEY_PROG   = 8'hA0;
  localparam logic [7:0]  KEY_RESET  = 8'hF0;
  localparam logic [15:0] OFF_HI     = 16'h0555;
  localparam logic [15:0] OFF_LO     = 16'h02AA;

  // 1 when writing nw over old would require any bit to rise
  function automatic logic needs_raise(input logic [15:0] old, input logic [15:0] nw);
    return |(nw & ~old);
  endfunction

  // Status word seen on reads while the algorithm owns the array
  function automatic logic [15:0] status_word(input logic [15:0] data, input logic tog,
                                              input logic tmo);
    logic [15:0] sw;
    sw    = '0;
    sw[7] = ~data[7];
    sw[6] = tog;
    sw[5] = tmo;
    return sw;
  endfunction

  // Value left in a word whose programming was cut by reset
  function automatic logic [15:0] corrupt_word(input logic [15:0] data);
    return ~data;
  endfunction

endpackage

// File: rtl/fwp_cmd_decode.sv
module fwp_cmd_decode #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              start
);
  import fwp_pkg::*;

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFF_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFF_LO);

  logic [1:0] step_q;
  logic       hit_first, hit_second, hit_prog;

  assign hit_first  = (addr == A_HI) && (wbyte == KEY_FIRST);
  assign hit_second = (addr == A_LO) && (wbyte == KEY_SECOND);
  assign hit_prog   = (addr == A_HI) && (wbyte == KEY_PROG);
  assign start      = en && we && (step_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 2'd0;
    end else if (en && we) begin
      case (step_q)
        2'd0:    step_q <= hit_first  ? 2'd1 : 2'd0;
        2'd1:    step_q <= hit_second ? 2'd2 : 2'd0;
        2'd2:    step_q <= hit_prog   ? 2'd3 : 2'd0;
        default: step_q <= 2'd0;
      endcase
    end
  end

  AST_START_AFTER_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we && (step_q == 2'd2) && hit_prog) |=> (step_q == 2'd3)); // R1

endmodule

// File: rtl/fwp_busy_timer.sv
module fwp_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |-> (cnt_q < limit)); // R9

endmodule

// File: rtl/fwp_array.sv
module fwp_array #(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [ADDR_W-2:0] rd_addr,
  output logic [15:0]       rd_word,
  input  logic              prog_we,
  input  logic [ADDR_W-2:0] prog_addr,
  input  logic [15:0]       prog_data,
  input  logic              erase_we,
  input  logic [SECT_W-1:0] erase_sect
);
  import fwp_pkg::*;

  localparam int WA_W  = ADDR_W - 1;
  localparam int WORDS = 1 << WA_W;
  localparam int PG_W  = WA_W - SECT_W;

  logic [15:0] mem [WORDS];
  logic        cut_we;

  assign rd_word = mem[rd_addr];
  assign cut_we  = !rst_n && busy;

  always_ff @(posedge clk) begin
    if (cut_we) begin
      mem[prog_addr] <= corrupt_word(prog_data);
    end else if (rst_n && prog_we) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end else if (rst_n && erase_we) begin
      for (int i = 0; i < WORDS; i++) begin
        if ((i >> PG_W) == int'(erase_sect)) mem[WA_W'(i)] <= '1;
      end
    end
  end

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((mem[$past(prog_addr)] & ~$past(mem[prog_addr])) == 16'h0)); // R4

endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog #(
  parameter int ADDR_W      = 11,
  parameter int SECT_W      = 2,
  parameter int PROG_CYC    = 8,
  parameter int TIMEOUT_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [15:0]       bus_rdata,
  input  logic              erase_req,
  input  logic [SECT_W-1:0] erase_sect
);
  import fwp_pkg::*;

  localparam int WA_W  = ADDR_W - 1;
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  fwp_state_e       st_q;
  logic [WA_W-1:0]  tgt_addr_q;
  logic [15:0]      tgt_data_q;
  logic             tgt_ok_q;
  logic             tog_q;
  logic [15:0]      rdata_q;

  logic [15:0]      rd_word;
  logic             cmd_start;
  logic             tmr_expire;
  logic             prog_commit;
  logic             status_rd;
  logic             busy_rd;
  logic             fail_clear;
  logic [CNT_W-1:0] tmr_limit;

  assign status_rd   = bus_re && !bus_we;
  assign busy_rd     = status_rd && (st_q == ST_BUSY);
  assign fail_clear  = (st_q == ST_FAIL) && bus_we && (bus_wdata[7:0] == KEY_RESET);
  assign prog_commit = (st_q == ST_BUSY) && tmr_expire;
  assign tmr_limit   = tgt_ok_q ? CNT_W'(PROG_CYC) : CNT_W'(TIMEOUT_CYC);
  assign bus_rdata   = rdata_q;

  fwp_cmd_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st_q == ST_READ),
    .we    (bus_we),
    .addr  (bus_addr),
    .wbyte (bus_wdata[7:0]),
    .start (cmd_start)
  );

  fwp_busy_timer #(.CNT_W(CNT_W)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cmd_start),
    .run    (st_q == ST_BUSY),
    .limit  (tmr_limit),
    .expire (tmr_expire)
  );

  fwp_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (st_q == ST_BUSY),
    .rd_addr    (bus_addr[ADDR_W-1:1]),
    .rd_word    (rd_word),
    .prog_we    (prog_commit),
    .prog_addr  (tgt_addr_q),
    .prog_data  (tgt_data_q),
    .erase_we   (erase_req && (st_q == ST_READ)),
    .erase_sect (erase_sect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_READ;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      tgt_ok_q   <= 1'b0;
      tog_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      case (st_q)
        ST_READ: if (cmd_start) begin
          tgt_addr_q <= bus_addr[ADDR_W-1:1];
          tgt_data_q <= bus_wdata;
          tgt_ok_q   <= !needs_raise(rd_word, bus_wdata);
          tog_q      <= 1'b0;
          st_q       <= bus_addr[0] ? ST_FAIL : ST_BUSY;
        end
        ST_BUSY: if (tmr_expire) st_q <= tgt_ok_q ? ST_READ : ST_FAIL;
        default: if (fail_clear) st_q <= ST_READ;
      endcase
      if (status_rd) begin
        case (st_q)
          ST_READ: rdata_q <= rd_word;
          ST_BUSY: begin
            rdata_q <= status_word(tgt_data_q, tog_q, 1'b0);
            tog_q   <= ~tog_q;
          end
          default: rdata_q <= status_word(tgt_data_q, tog_q, 1'b1);
        endcase
      end
    end
  end

  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |=> ($stable(tgt_data_q) && $stable(tgt_addr_q))); // R6

  AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd |=> (bus_rdata[7] == ~tgt_data_q[7])); // R7

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd ##1 busy_rd |=> (bus_rdata[6] != $past(bus_rdata[6]))); // R8

  AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FAIL) && status_rd) |=> bus_rdata[5]); // R5

  AST_ODD_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && bus_addr[0]) |=> (st_q == ST_FAIL)); // R2

  AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_READ) && status_rd) |=> (bus_rdata[15:8] == 8'h0 && bus_rdata[4:0] == 5'h0)); // R13

endmodule

// File: tb/test_flash_word_prog.sv
module test_flash_word_prog;

  localparam int AW    = 11;
  localparam int PROG  = 8;
  localparam int TMO   = 40;
  localparam int NWORD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [15:0]   bus_rdata;
  logic          erase_req = 1'b0;
  logic [1:0]    erase_sect = '0;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R13";

  // behavioural reference model state
  logic [15:0] m_mem [NWORD];
  int          m_mode = 0;   // 0 array read, 1 busy, 2 error
  int          m_step = 0;
  int          m_cnt = 0;
  int          m_lim = 0;
  int          m_tw = 0;
  logic [15:0] m_td = '0;
  logic        m_tog = 1'b0;
  logic [15:0] m_rd = '0;

  always #4 clk = ~clk;

  flash_word_prog i_flash_word_prog (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .erase_req  (erase_req),
    .erase_sect (erase_sect)
  );

  function automatic logic [15:0] stat(input logic [15:0] d, input logic t, input logic e);
    logic [15:0] s;
    s = 16'h0;
    if (d[7] == 1'b0) s = s | 16'h0080;
    if (t) s = s | 16'h0040;
    if (e) s = s | 16'h0020;
    return s;
  endfunction

  always @(posedge clk) begin
    int pmode;
    pmode = m_mode;
    if (!rst_n) begin
      if (pmode == 1) m_mem[m_tw] = ~m_td;
      m_mode = 0; m_step = 0; m_rd = 16'h0; m_tog = 1'b0;
    end else begin
      if (bus_re && !bus_we) begin
        if (pmode == 0) m_rd = m_mem[int'(bus_addr) / 2];
        else if (pmode == 1) begin
          m_rd = stat(m_td, m_tog, 1'b0);
          m_tog = ~m_tog;
        end else m_rd = stat(m_td, m_tog, 1'b1);
      end
      if (pmode == 1) begin
        m_cnt++;
        if (m_cnt == m_lim) begin
          m_mem[m_tw] = m_mem[m_tw] & m_td;
          m_mode = (m_lim == PROG) ? 0 : 2;
        end
      end else if (pmode == 2) begin
        if (bus_we && bus_wdata[7:0] == 8'hF0) m_mode = 0;
      end else begin
        if (erase_req)
          for (int i = 0; i < NWORD; i++)
            if (i / 256 == int'(erase_sect)) m_mem[i] = 16'hFFFF;
        if (bus_we) begin
          if (m_step == 0) m_step = (bus_addr == 11'h555 && bus_wdata[7:0] == 8'hAA) ? 1 : 0;
          else if (m_step == 1) m_step = (bus_addr == 11'h2AA && bus_wdata[7:0] == 8'h55) ? 2 : 0;
          else if (m_step == 2) m_step = (bus_addr == 11'h555 && bus_wdata[7:0] == 8'hA0) ? 3 : 0;
          else begin
            m_step = 0;
            m_td = bus_wdata;
            m_tog = 1'b0;
            m_tw = int'(bus_addr) / 2;
            m_cnt = 0;
            if (bus_addr[0]) m_mode = 2;
            else begin
              m_mode = 1;
              m_lim = ((bus_wdata & ~m_mem[m_tw]) == 16'h0) ? PROG : TMO;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_chk++;
      if (bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h at %0t", cur_req, bus_rdata, m_rd, $time);
      end
    end
  end

  task automatic drive(input logic we, input logic re, input logic [AW-1:0] a,
                       input logic [15:0] d);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; erase_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    drive(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    drive(1'b0, 1'b1, a, '0);
  endtask

  task automatic rd_n(input logic [AW-1:0] a, input int n);
    for (int k = 0; k < n; k++) rd(a);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase(input logic [1:0] s);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0; erase_req = 1'b1; erase_sect = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    started = 1'b1;
    cur_req = "R13";              // reset value of read data
    idle(2);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R12";              // erase all sectors
    for (int s = 0; s < 4; s++) erase(2'(s));
    idle(1); rd(11'h020); rd(11'h3FE); rd(11'h7FE); idle(1);
    cur_req = "R9";               // clean program, busy length and status phase
    prog(11'h020, 16'h1234);
    cur_req = "R8";
    rd_n(11'h020, PROG + 3);
    cur_req = "R4";
    rd(11'h020); idle(1);
    cur_req = "R3";               // neighbours unchanged
    rd(11'h022); rd(11'h01E); idle(1);
    cur_req = "R6";               // second command during busy
    prog(11'h040, 16'h00FF);
    prog(11'h060, 16'h0000);
    idle(PROG);
    rd(11'h060); rd(11'h040); idle(1);
    cur_req = "R5";               // raise attempt times out
    prog(11'h040, 16'h0F0F);
    rd_n(11'h040, TMO + 4);
    cur_req = "R11";              // error state ignores commands
    prog(11'h080, 16'h0000);
    idle(PROG + 2);
    rd(11'h080); rd(11'h080);
    wr(11'h000, 16'h00F0);
    rd(11'h080);
    cur_req = "R7";               // zeros applied, true data read back
    rd(11'h040); idle(1);
    cur_req = "R2";               // odd address
    prog(11'h051, 16'h0000);
    rd_n(11'h050, 4);
    wr(11'h000, 16'h00F0);
    rd(11'h050); idle(1);
    cur_req = "R1";               // broken unlock sequence
    wr(11'h555, 16'h00AA); wr(11'h123, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h070, 16'h0000);
    rd(11'h070); rd(11'h070);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h2AA, 16'h00A0); wr(11'h070, 16'h0000);
    rd(11'h070); idle(1);
    cur_req = "R11";              // abort with 0xF0 mid-sequence
    wr(11'h555, 16'h00AA); wr(11'h000, 16'h00F0); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
    wr(11'h072, 16'h0000);
    rd(11'h072); idle(1);
    cur_req = "R10";              // reset while busy
    prog(11'h090, 16'h1111);
    rd_n(11'h090, 3);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    rd(11'h090); rd(11'h092); idle(1);
    cur_req = "R12";              // erase ignored while busy, then applied per sector
    prog(11'h200, 16'h0000);
    idle(PROG + 1);
    prog(11'h0A0, 16'h0000);
    erase(2'd0);
    idle(PROG + 1);
    rd(11'h0A0);
    erase(2'd0);
    idle(1);
    rd(11'h0A0); rd(11'h020); rd(11'h200); rd(11'h040); idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule